// File: doc/BRIEF.md
# Reconfigurable Dual/Single Line Decoder

This block is an address decoder with eight outputs that can be set up in two ways. With the mode input low, it works as two separate 1-of-4 decoders. Group a drives the lower four outputs and group b drives the upper four. Each group has its own 2-bit address and its own pair of active-low enables. With the mode input high, the block works as one 1-of-8 decoder. The 3-bit address of group a then picks one of all eight outputs, and the four enable lines act as two shared enables.

Three polarity inputs set the level of each half. A half is active-high when its own select differs from the common select. Otherwise every output of that half is inverted, so an idle half rests high. The single-mode decoder is made from the same two 4-output decoders, with the top address bit choosing the bank.

A parameter can add one output register. When it is present, the outputs follow the inputs one clock later, and a synchronous reset drives every output to its inactive level for the current polarity inputs. Without it the block is purely combinational, and the clock and reset have no effect. The decoder exchanges no data items, so every pin is a plain level and there is no valid/ready handshake and no back-pressure.

Top module: `dual_mode_line_decoder`

## Requirements
- R1: Dual mode (mode_single = 0) with both en_a_n bits low: exactly the output dec_o[addr_a[1:0]] is in its active state within dec_o[3:0].
- R2: Dual mode with both en_b_n bits low: exactly the output dec_o[4 + addr_b] is in its active state within dec_o[7:4].
- R3: In dual mode, addr_a[2] has no effect on dec_o.
- R4: In dual mode, a group with either of its enable bits high holds all four of its outputs inactive, and group a depends only on en_a_n while group b depends only on en_b_n.
- R5: Single mode (mode_single = 1) with all four enable bits low: exactly dec_o[addr_a] (index 0..7) is active; indices 0..3 lie in the group a half and 4..7 in the group b half.
- R6: In single mode, any enable bit high puts all eight outputs in the inactive state.
- R7: In single mode, addr_b has no effect on dec_o.
- R8: The lower half is active-high when pol_a XOR pol_c is 1, and the upper half when pol_b XOR pol_c is 1. When that XOR is 0, every output of the half is inverted: active is 0 and inactive is 1.
- R9: In each half, at most one output is ever in its active state.
- R10: With REG_OUT = 1, dec_o shows the decode of the inputs sampled at the previous rising clk edge. A cycle with rst high sets every output to its inactive level for the polarity inputs sampled at that edge.
- R11: With REG_OUT = 0, dec_o follows the inputs in the same cycle, and rst has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset (registered build only) |
| mode_single | input | 1 | 0: two 1-of-4 decoders, 1: one 1-of-8 decoder |
| addr_a | input | ADDR_W+1 | Group a address; the top bit is used only in single mode |
| addr_b | input | ADDR_W | Group b address; used only in dual mode |
| en_a_n | input | 2 | Group a active-low enable pair |
| en_b_n | input | 2 | Group b active-low enable pair |
| pol_a | input | 1 | Polarity select, lower half |
| pol_b | input | 1 | Polarity select, upper half |
| pol_c | input | 1 | Common polarity select |
| dec_o | output | 2*2**ADDR_W | Decoded outputs; lower half is group a |

## Verification
The bench builds two copies, both with ADDR_W = 2. One has REG_OUT = 0, where each input vector is compared with the output in the same cycle. The other has REG_OUT = 1, where a queue of expected words is matched against the output one clock later, and the reset level is checked under two polarity settings. Together the copies sweep all 8192 combinations of mode, address, enable and polarity, which reaches every enable pattern that disables a group, every polarity mix of the two halves, and the ignored address bits in both modes.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  typedef enum logic {
    MODE_DUAL   = 1'b0,
    MODE_SINGLE = 1'b1
  } dmd_mode_e;
endpackage

// File: rtl/dmd_steer.sv
// Turns mode, enables and addresses into a per-bank enable and select.
// Single mode reuses both banks, with the top address bit choosing between them.
module dmd_steer
  import dmd_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                   mode_single,
  input  logic [ADDR_W:0]        addr_a,
  input  logic [ADDR_W-1:0]      addr_b,
  input  logic [1:0]             en_a_n,
  input  logic [1:0]             en_b_n,
  output logic [1:0]             grp_en,
  output logic [1:0][ADDR_W-1:0] grp_sel
);
  logic all_low;

  always_comb begin
    // Shared enables in single mode behave like wired lines: any high disables.
    all_low = ~|{en_a_n, en_b_n};
    if (dmd_mode_e'(mode_single) == MODE_SINGLE) begin
      grp_en[0]  = all_low & ~addr_a[ADDR_W];
      grp_en[1]  = all_low &  addr_a[ADDR_W];
      grp_sel[0] = addr_a[ADDR_W-1:0];
      grp_sel[1] = addr_a[ADDR_W-1:0];
    end else begin
      grp_en[0]  = ~|en_a_n;
      grp_en[1]  = ~|en_b_n;
      grp_sel[0] = addr_a[ADDR_W-1:0];
      grp_sel[1] = addr_b;
    end
  end
endmodule

// File: rtl/dmd_group_dec.sv
// One-hot decode of a bank select, gated by the bank enable.
module dmd_group_dec #(
  parameter int ADDR_W = 2,
  localparam int OUTS  = 1 << ADDR_W
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] sel,
  output logic [OUTS-1:0]   hot
);
  for (genvar i = 0; i < OUTS; i++) begin : g_line
    assign hot[i] = en && (sel == ADDR_W'(i));
  end
endmodule

// File: rtl/dmd_out_stage.sv
// Applies the polarity mask, either directly or through a register.
module dmd_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hot,
  input  logic [W-1:0] inv,
  output logic [W-1:0] q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= inv;          // inactive level = mask alone
      else     q <= hot ^ inv;
    end
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    assign q = hot ^ inv;
  end
endmodule

// File: rtl/dual_mode_line_decoder.sv
module dual_mode_line_decoder #(
  parameter int ADDR_W  = 2,
  parameter bit REG_OUT = 1'b0,
  localparam int GRP    = 1 << ADDR_W,
  localparam int OUT_W  = 2 * GRP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_single,
  input  logic [ADDR_W:0]   addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [1:0]        en_a_n,
  input  logic [1:0]        en_b_n,
  input  logic              pol_a,
  input  logic              pol_b,
  input  logic              pol_c,
  output logic [OUT_W-1:0]  dec_o
);
  logic [1:0]             grp_en;
  logic [1:0][ADDR_W-1:0] grp_sel;
  logic [OUT_W-1:0]       hot;
  logic [OUT_W-1:0]       inv;
  logic [1:0]             half_hi;

  dmd_steer #(.ADDR_W(ADDR_W)) u_steer (
    .mode_single (mode_single),
    .addr_a      (addr_a),
    .addr_b      (addr_b),
    .en_a_n      (en_a_n),
    .en_b_n      (en_b_n),
    .grp_en      (grp_en),
    .grp_sel     (grp_sel)
  );

  assign half_hi[0] = pol_a ^ pol_c;
  assign half_hi[1] = pol_b ^ pol_c;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    dmd_group_dec #(.ADDR_W(ADDR_W)) u_dec (
      .en  (grp_en[g]),
      .sel (grp_sel[g]),
      .hot (hot[g*GRP +: GRP])
    );
    assign inv[g*GRP +: GRP] = {GRP{~half_hi[g]}};
  end

  dmd_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
    .clk (clk),
    .rst (rst),
    .hot (hot),
    .inv (inv),
    .q   (dec_o)
  );
endmodule

// File: rtl/dmd_checker.sv
module dmd_checker #(
  parameter int ADDR_W  = 2,
  parameter bit REG_OUT = 1'b0,
  localparam int GRP    = 1 << ADDR_W,
  localparam int OUT_W  = 2 * GRP
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_single,
  input logic [ADDR_W:0]   addr_a,
  input logic [ADDR_W-1:0] addr_b,
  input logic [1:0]        en_a_n,
  input logic [1:0]        en_b_n,
  input logic              pol_a,
  input logic              pol_b,
  input logic              pol_c,
  input logic [OUT_W-1:0]  dec_o
);
  localparam logic [GRP-1:0]   ONE_G = 1;
  localparam logic [OUT_W-1:0] ONE_W = 1;

  // Inputs as seen by the current output value.
  logic              v_rst, v_mode, v_pa, v_pb, v_pc;
  logic [ADDR_W:0]   v_aa;
  logic [ADDR_W-1:0] v_ab;
  logic [1:0]        v_ea, v_eb;
  logic              primed = 1'b0;

  always_ff @(posedge clk) primed <= 1'b1;

  if (REG_OUT) begin : g_view_reg
    always_ff @(posedge clk) begin
      v_rst  <= rst;
      v_mode <= mode_single;
      v_aa   <= addr_a;
      v_ab   <= addr_b;
      v_ea   <= en_a_n;
      v_eb   <= en_b_n;
      v_pa   <= pol_a;
      v_pb   <= pol_b;
      v_pc   <= pol_c;
    end
  end else begin : g_view_comb
    assign v_rst  = 1'b0;
    assign v_mode = mode_single;
    assign v_aa   = addr_a;
    assign v_ab   = addr_b;
    assign v_ea   = en_a_n;
    assign v_eb   = en_b_n;
    assign v_pa   = pol_a;
    assign v_pb   = pol_b;
    assign v_pc   = pol_c;
  end

  logic [GRP-1:0] act_a, act_b;
  assign act_a = dec_o[GRP-1:0]     ^ {GRP{~(v_pa ^ v_pc)}};
  assign act_b = dec_o[OUT_W-1:GRP] ^ {GRP{~(v_pb ^ v_pc)}};

  p_half_onehot_r9: assert property (@(posedge clk) disable iff (!primed)
    $onehot0(act_a) && $onehot0(act_b));

  p_dual_a_r1: assert property (@(posedge clk) disable iff (v_rst || !primed)
    (!v_mode && v_ea == 2'b00) |-> act_a == (ONE_G << v_aa[ADDR_W-1:0]));

  p_dual_b_r2: assert property (@(posedge clk) disable iff (v_rst || !primed)
    (!v_mode && v_eb == 2'b00) |-> act_b == (ONE_G << v_ab));

  p_dual_a_off_r4: assert property (@(posedge clk) disable iff (v_rst || !primed)
    (!v_mode && v_ea != 2'b00) |-> act_a == '0);

  p_dual_b_off_r4: assert property (@(posedge clk) disable iff (v_rst || !primed)
    (!v_mode && v_eb != 2'b00) |-> act_b == '0);

  p_single_dec_r5: assert property (@(posedge clk) disable iff (v_rst || !primed)
    (v_mode && {v_ea, v_eb} == 4'b0000) |-> {act_b, act_a} == (ONE_W << v_aa));

  p_single_off_r6: assert property (@(posedge clk) disable iff (v_rst || !primed)
    (v_mode && {v_ea, v_eb} != 4'b0000) |-> {act_b, act_a} == '0);

  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!primed)
    v_rst |-> {act_b, act_a} == '0);
endmodule

bind dual_mode_line_decoder dmd_checker #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_single (mode_single),
  .addr_a      (addr_a),
  .addr_b      (addr_b),
  .en_a_n      (en_a_n),
  .en_b_n      (en_b_n),
  .pol_a       (pol_a),
  .pol_b       (pol_b),
  .pol_c       (pol_c),
  .dec_o       (dec_o)
);

// File: tb/dual_mode_line_decoder_tb.sv
`timescale 1ns/1ps
module dual_mode_line_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_single = 1'b0;
  logic [2:0] addr_a = '0;
  logic [1:0] addr_b = '0;
  logic [1:0] en_a_n = '0;
  logic [1:0] en_b_n = '0;
  logic       pol_a = 1'b0, pol_b = 1'b0, pol_c = 1'b0;
  logic [7:0] dec_reg, dec_comb;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  dual_mode_line_decoder #(.ADDR_W(2), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .mode_single(mode_single), .addr_a(addr_a),
    .addr_b(addr_b), .en_a_n(en_a_n), .en_b_n(en_b_n), .pol_a(pol_a),
    .pol_b(pol_b), .pol_c(pol_c), .dec_o(dec_reg));

  dual_mode_line_decoder #(.ADDR_W(2), .REG_OUT(1'b0)) u_comb (
    .clk(clk), .rst(rst), .mode_single(mode_single), .addr_a(addr_a),
    .addr_b(addr_b), .en_a_n(en_a_n), .en_b_n(en_b_n), .pol_a(pol_a),
    .pol_b(pol_b), .pol_c(pol_c), .dec_o(dec_comb));

  // Reference built from the requirements (R1, R2, R4, R5, R6, R8).
  function automatic logic [7:0] model(input logic [12:0] v);
    logic [7:0] raw = '0;
    logic ha, hb;
    if (!v[12]) begin
      if (v[6:5] == 2'b00) raw[v[10:9]] = 1'b1;
      if (v[4:3] == 2'b00) raw[4 + v[8:7]] = 1'b1;
    end else if (v[6:3] == 4'b0000) begin
      raw[v[11:9]] = 1'b1;
    end
    ha = v[2] ^ v[0];
    hb = v[1] ^ v[0];
    return raw ^ {{4{~hb}}, {4{~ha}}};
  endfunction

  function automatic string tag_of(input logic [12:0] v);
    if (!v[12]) return (v[6:3] != 4'b0000) ? "R4" : "R1";
    return (v[6:3] != 4'b0000) ? "R6" : "R5";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply vector at negedge, check the combinational copy now (R11),
  // push expectation for the registered copy (R10).
  task automatic drive(input logic [12:0] v, input logic [7:0] exp, input string tag);
    logic [3:0] act_lo, act_hi;
    @(negedge clk);
    mode_single = v[12]; addr_a = v[11:9]; addr_b = v[8:7];
    en_a_n = v[6:5]; en_b_n = v[4:3]; pol_a = v[2]; pol_b = v[1]; pol_c = v[0];
    #1;
    check({tag, " R11 comb"}, dec_comb, exp);
    // R9: at most one active line per half
    act_lo = dec_comb[3:0] ^ {4{~(v[2] ^ v[0])}};
    act_hi = dec_comb[7:4] ^ {4{~(v[1] ^ v[0])}};
    checks++;
    if ($countones(act_lo) > 1 || $countones(act_hi) > 1) begin
      fails++;
      $display("FAIL R9 actual=%h expected=at most one active per half", dec_comb);
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: pops one expectation per rising edge for the registered copy.
  always @(posedge clk) begin
    #1;
    if (mon_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " R10 reg"}, dec_reg, e);
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // Reset with all polarity low: inactive level is high everywhere (R10).
    repeat (2) @(posedge clk);
    #1;
    check("R10 reset all-low pol", dec_reg, 8'hFF);
    // R11: combinational copy decodes despite rst (dual, enabled, addr 0/0).
    check("R11 rst ignored", dec_comb, 8'hEE);
    @(negedge clk);
    pol_a = 1'b1;  // lower half active-high, upper half still inverted
    @(posedge clk);
    #1;
    check("R10 reset mixed pol", dec_reg, 8'hF0);
    @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;

    // R3: addr_a[2] ignored in dual mode; a idx 2, b idx 1, active-high.
    drive({1'b0, 3'b010, 2'b01, 2'b00, 2'b00, 3'b110}, 8'h24, "R3");
    drive({1'b0, 3'b110, 2'b01, 2'b00, 2'b00, 3'b110}, 8'h24, "R3");
    // R7: addr_b ignored in single mode; index 5 active-high.
    drive({1'b1, 3'b101, 2'b00, 2'b00, 2'b00, 3'b001}, 8'h20, "R7");
    drive({1'b1, 3'b101, 2'b11, 2'b00, 2'b00, 3'b001}, 8'h20, "R7");
    // R8: common select low inverts every output in single mode.
    drive({1'b1, 3'b101, 2'b00, 2'b00, 2'b00, 3'b000}, 8'hDF, "R8");
    // R8: lower half inverted, upper half active-high in dual mode.
    drive({1'b0, 3'b001, 2'b10, 2'b00, 2'b00, 3'b010}, 8'h4D, "R8");
    // R4: group b disabled by one enable bit, group a unaffected.
    drive({1'b0, 3'b011, 2'b10, 2'b00, 2'b10, 3'b110}, 8'h08, "R4");
    // R6: one enable of group b high kills the whole single decoder.
    drive({1'b1, 3'b011, 2'b00, 2'b00, 2'b01, 3'b001}, 8'h00, "R6");

    // Full sweep of every input combination (R1, R2, R4, R5, R6, R8).
    for (int i = 0; i < 8192; i++) begin
      logic [12:0] v;
      v = 13'(i);
      drive(v, model(v), tag_of(v));
    end
    repeat (3) @(posedge clk);
    #1;
    finish_run();
  end
endmodule